// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This engine draws into a frame memory that holds one byte per pixel. Software drives it through a window of 32-bit writes, and each command takes two of them. A write to an even word (address bit 2 clear) stores a colour. A write to an odd word (address bit 2 set) starts an operation. For that write, the bus address gives the destination pixel and the data word gives the operation's parameters.

The `blitMode` input selects one of two operations. With `blitMode` low, the data word is a 32-bit stipple mask, and the stored colour is painted wherever the mask has a one. With `blitMode` high, the data word is a run descriptor. If its source field is all ones, the run is filled with the colour. Any other source value copies the run from that source pixel address.

The engine drives a memory port that moves one byte per cycle, and it raises `busy` while it works. When an operation ends, a `done` pulse is issued. The destination start and the run length are reported together so that a display path can track which pixels are dirty.

Top module: `sbe_top`

## Requirements
- R1: A full-width write with address bit 2 clear stores the low byte of the data as the drawing colour. It causes no memory access, and no memory strobe is ever raised while the engine is idle.
- R2: A full-width write with address bit 2 set starts a command. The destination pixel is bus address bits 22:3, so address bits above 22 have no effect.
- R3: Stipple (blitMode=0) runs 32 pixel slots, one per cycle. Mask bit 31 maps to destination+0 and bit 0 to destination+31. A set bit writes the colour, and a clear bit leaves its pixel unchanged.
- R4: Blit (blitMode=1) takes the source from data bits 23:0 and the run length from data bits 28:24 plus one, so runs are 1 to 32 pixels long.
- R5: A source field of 0xFFFFFF fills the run with the colour, at one pixel per cycle.
- R6: Any other source value copies the run in ascending address order. Each pixel takes a read cycle and then a write cycle, so an overlapping run sees bytes already written earlier in the same run.
- R7: While an operation runs, busy is high and busReady is low. Any write presented during that time, whether colour or command, waits and takes effect only after busReady returns high.
- R8: Reads return zero and change nothing. Writes whose byte enables are not all ones are ignored.
- R9: done pulses for one cycle in the cycle after the last pixel step, as busy falls. dirtyStart holds the destination, and dirtyLen holds the run length (32 for stipple).
- R10: After reset the engine is idle, busReady is high, done is low and the colour is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 24 | Byte address within the command window |
| busByteEn | input | 4 | Byte enables; only 4'hF is honoured |
| busWdata | input | 32 | Write data |
| blitMode | input | 1 | 0 = stipple, 1 = blit |
| busReady | output | 1 | Access accepted this cycle when high |
| busRdata | output | 32 | Read data, always zero |
| memAddr | output | 24 | Frame memory pixel address |
| memWe | output | 1 | Frame memory byte write |
| memRe | output | 1 | Frame memory byte read, data one cycle later |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte read back |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| dirtyStart | output | 20 | Destination start of the last command |
| dirtyLen | output | 6 | Pixel count of the last command |

## Verification
The bench sweeps every fill and copy length from 1 to 32, a set of stipple masks (all ones, all zeros, the end bits only, alternating), and copies whose source lies one pixel below or above the destination. If the length decode were off by one, the run would overrun or fall short. A reversed mask order would paint the run mirrored. A copy that read ahead or ran descending would break the propagating overlap pattern. Stalled writes during busy, partial-width writes and reads are all checked for leaving memory and colour untouched. An engine that accepted early would paint the queued colour into the earlier stipple.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STIP,
    ST_FILL,
    ST_CRD,
    ST_CWR
  } sbeState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchColor;
    logic loadCmd;
    logic advance;
    logic doRead;
    logic doWrite;
    logic fromMem;
    logic gateMask;
  } sbeStrobe_t;

endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
#(
  parameter int SRC_AW = 24,
  parameter int LEN_W  = 5,
  parameter int MASK_W = 32,
  parameter int CNT_W  = $clog2(MASK_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              oddWord,
  input  logic [3:0]        busByteEn,
  input  logic [SRC_AW-1:0] srcField,
  input  logic [LEN_W-1:0]  runField,
  input  logic              blitMode,
  output sbeStrobe_t        strb,
  output logic              busReady,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  dirtyLen
);

  sbeState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             accept, startHit, latchHit, isFill, lastStep;

  assign busReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign accept   = busValid && busWrite && (busByteEn == 4'hF) && busReady;
  assign startHit = accept && oddWord;
  assign latchHit = accept && !oddWord;
  assign isFill   = &srcField;

  always_comb begin
    strb            = '0;
    strb.latchColor = latchHit;
    strb.loadCmd    = startHit;
    nextState       = state;
    nextCnt         = cnt;
    lastStep        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startHit) begin
          if (blitMode) begin
            nextState = isFill ? ST_FILL : ST_CRD;
            nextCnt   = CNT_W'(runField);
          end else begin
            nextState = ST_STIP;
            nextCnt   = CNT_W'(MASK_W - 1);
          end
        end
      end
      ST_STIP: begin
        strb.doWrite  = 1'b1;
        strb.gateMask = 1'b1;
        strb.advance  = 1'b1;
      end
      ST_FILL: begin
        strb.doWrite = 1'b1;
        strb.advance = 1'b1;
      end
      ST_CRD: begin
        strb.doRead = 1'b1;
        nextState   = ST_CWR;
      end
      ST_CWR: begin
        strb.doWrite = 1'b1;
        strb.fromMem = 1'b1;
        strb.advance = 1'b1;
        nextState    = ST_CRD;
      end
      default: nextState = ST_IDLE;
    endcase
    if (state != ST_IDLE && strb.advance) begin
      if (cnt == '0) begin
        lastStep  = 1'b1;
        nextState = ST_IDLE;
      end else begin
        nextCnt = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      dirtyLen <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      done  <= lastStep;
      if (startHit) begin
        dirtyLen <= blitMode ? CNT_W'(runField) + 1'b1 : CNT_W'(MASK_W);
      end
    end
  end

endmodule

// File: rtl/sbe_datapath.sv
module sbe_datapath
  import sbe_pkg::*;
#(
  parameter int DST_AW = 20,
  parameter int SRC_AW = 24,
  parameter int PIX_W  = 8,
  parameter int MASK_W = 32,
  parameter int CNT_W  = $clog2(MASK_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbeStrobe_t        strb,
  input  logic [DST_AW-1:0] dstIn,
  input  logic [MASK_W-1:0] dataIn,
  input  logic [PIX_W-1:0]  memRdata,
  output logic [SRC_AW-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [PIX_W-1:0]  memWdata,
  output logic [DST_AW-1:0] dirtyStart
);

  logic [PIX_W-1:0]  colorQ;
  logic [DST_AW-1:0] dstQ;
  logic [SRC_AW-1:0] srcQ;
  logic [MASK_W-1:0] maskQ;
  logic [CNT_W-1:0]  idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorQ <= '0;
      dstQ   <= '0;
      srcQ   <= '0;
      maskQ  <= '0;
      idxQ   <= '0;
    end else begin
      if (strb.latchColor) colorQ <= dataIn[PIX_W-1:0];
      if (strb.loadCmd) begin
        dstQ  <= dstIn;
        srcQ  <= dataIn[SRC_AW-1:0];
        maskQ <= dataIn;
        idxQ  <= '0;
      end else if (strb.advance) begin
        idxQ  <= idxQ + 1'b1;
        maskQ <= {maskQ[MASK_W-2:0], 1'b0};
      end
    end
  end

  assign memAddr    = strb.doRead ? (srcQ + SRC_AW'(idxQ))
                                  : (SRC_AW'(dstQ) + SRC_AW'(idxQ));
  assign memRe      = strb.doRead;
  assign memWe      = strb.doWrite && (!strb.gateMask || maskQ[MASK_W-1]);
  assign memWdata   = strb.fromMem ? memRdata : colorQ;
  assign dirtyStart = dstQ;

endmodule

// File: rtl/sbe_top.sv
module sbe_top
  import sbe_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int DST_AW = 20,
  parameter int SRC_AW = 24,
  parameter int LEN_W  = 5,
  parameter int PIX_W  = 8,
  parameter int MASK_W = 32,
  parameter int CNT_W  = $clog2(MASK_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [MASK_W-1:0] busWdata,
  input  logic              blitMode,
  output logic              busReady,
  output logic [MASK_W-1:0] busRdata,
  output logic [SRC_AW-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [PIX_W-1:0]  memWdata,
  input  logic [PIX_W-1:0]  memRdata,
  output logic              busy,
  output logic              done,
  output logic [DST_AW-1:0] dirtyStart,
  output logic [CNT_W-1:0]  dirtyLen
);

  sbeStrobe_t strb;

  assign busRdata = '0;

  sbe_ctrl #(
    .SRC_AW(SRC_AW), .LEN_W(LEN_W), .MASK_W(MASK_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .oddWord  (busAddr[2]),
    .busByteEn(busByteEn),
    .srcField (busWdata[SRC_AW-1:0]),
    .runField (busWdata[SRC_AW +: LEN_W]),
    .blitMode (blitMode),
    .strb     (strb),
    .busReady (busReady),
    .busy     (busy),
    .done     (done),
    .dirtyLen (dirtyLen)
  );

  sbe_datapath #(
    .DST_AW(DST_AW), .SRC_AW(SRC_AW), .PIX_W(PIX_W),
    .MASK_W(MASK_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dstIn     (busAddr[3 +: DST_AW]),
    .dataIn    (busWdata),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memRe     (memRe),
    .memWdata  (memWdata),
    .dirtyStart(dirtyStart)
  );

endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
  parameter int BUS_AW = 24,
  parameter int DST_AW = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [BUS_AW-1:0] busAddr,
  input logic [3:0]        busByteEn,
  input logic              busReady,
  input logic              busy,
  input logic              done,
  input logic              memWe,
  input logic              memRe,
  input logic [DST_AW-1:0] dirtyStart
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe && !memRe); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busReady && busByteEn == 4'hF && busAddr[2] |=> busy); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> memWe && !memRe); // R6

  AST_NO_READ_WRITE_MIX: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R6

  AST_READ_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && !busy |=> !busy); // R8

  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busByteEn != 4'hF && !busy |=> !busy); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DIRTY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(dirtyStart)); // R9

endmodule

bind sbe_top sbe_checker #(.BUS_AW(BUS_AW), .DST_AW(DST_AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busByteEn (busByteEn),
  .busReady  (busReady),
  .busy      (busy),
  .done      (done),
  .memWe     (memWe),
  .memRe     (memRe),
  .dirtyStart(dirtyStart)
);

// File: tb/tb_sbe_top.sv
`timescale 1ns/1ps
module tb_sbe_top;

  localparam int MEMN = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, blitMode = 1'b0;
  logic [23:0] busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic        busReady, memWe, memRe, busy, done;
  logic [31:0] busRdata;
  logic [23:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic [19:0] dirtyStart;
  logic [5:0]  dirtyLen;

  logic [7:0] mem   [MEMN];
  logic [7:0] model [MEMN];

  int checks = 0, failures = 0, idleStrobes = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sbe_top dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .blitMode(blitMode), .busReady(busReady), .busRdata(busRdata),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done),
    .dirtyStart(dirtyStart), .dirtyLen(dirtyLen)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[11:0]];
    if (rstN && !busy && (memWe || memRe)) idleStrobes++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic busWr(input logic [23:0] a, input logic [31:0] d,
                       input logic [3:0] be);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d; busByteEn = be;
    while (!busReady) @(negedge clk);
    @(negedge clk);
    busValid = 0; busWrite = 0; busByteEn = 4'hF;
  endtask

  task automatic memCompare(string req);
    int bad = 0, firstBad = -1;
    for (int i = 0; i < MEMN; i++)
      if (mem[i] !== model[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    check(bad == 0, req, bad, 0);
    if (bad != 0)
      $display("  first mismatch at %0d: mem=%0h model=%0h", firstBad,
               mem[firstBad], model[firstBad]);
  endtask

  // Issue a command and wait for done; dst is a pixel address
  task automatic runCmd(input int dst, input logic [31:0] d, input bit mode,
                        input int expCycles, input int expLen, string req);
    int n;
    blitMode = mode;
    busWr({1'b1, 20'(dst), 3'b100}, d, 4'hF);  // bit 23 set: ignored (R2)
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == expCycles, req, n, expCycles);
    check(dirtyStart == 20'(dst) && dirtyLen == 6'(expLen), "R9 dirty report",
          {dirtyStart, 2'b00, dirtyLen}, {20'(dst), 2'b00, 6'(expLen)});
  endtask

  task automatic setColor(input logic [7:0] c);
    busWr(24'h000010, {24'hABCDEF, c}, 4'hF);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(!busy && busReady && !done && !memWe && !memRe, "R10 reset state",
          {busy, busReady, done}, 3'b010);

    // R10 colour resets to zero: fill before any colour write
    runCmd(5, {3'b000, 5'd3, 24'hFFFFFF}, 1, 5, 4, "R10 fill cycles");
    for (int i = 0; i < 4; i++) model[5 + i] = 8'h00;
    memCompare("R10 reset colour zero");

    // R1 colour latch makes no memory access
    setColor(8'h5A);
    memCompare("R1 colour latch no write");

    // R4 R5 fill sweep of all lengths
    for (int len = 1; len <= 32; len++) begin
      logic [7:0] c = 8'(len * 13 + 1);
      int dst = 40 + len * 40;
      setColor(c);
      runCmd(dst, {3'b000, 5'(len - 1), 24'hFFFFFF}, 1, len + 1, len,
             "R5 fill cycles");
      for (int i = 0; i < len; i++) model[dst + i] = c;
      memCompare("R4 R5 fill length");
    end

    // R6 copy sweep of all lengths, disjoint source
    for (int len = 1; len <= 32; len++) begin
      int src = 1600 + len * 3;
      int dst = 2000 + len * 40;
      runCmd(dst, {3'b000, 5'(len - 1), 24'(src)}, 1, 2 * len + 1, len,
             "R6 copy cycles");
      for (int i = 0; i < len; i++) model[dst + i] = model[src + i];
      memCompare("R4 R6 copy length");
    end

    // R6 overlap: source one below destination propagates first byte
    runCmd(3401, {3'b000, 5'd7, 24'd3400}, 1, 17, 8, "R6 overlap up cycles");
    for (int i = 0; i < 8; i++) model[3401 + i] = model[3400 + i];
    memCompare("R6 overlap source below");
    // source one above destination shifts down
    runCmd(3500, {3'b000, 5'd7, 24'd3501}, 1, 17, 8, "R6 overlap down cycles");
    for (int i = 0; i < 8; i++) model[3500 + i] = model[3501 + i];
    memCompare("R6 overlap source above");

    // R3 stipple masks
    begin
      logic [31:0] masks [5] = '{32'hFFFFFFFF, 32'h80000001, 32'hA5A5A5A5,
                                 32'h00000000, 32'h00000001};
      for (int k = 0; k < 5; k++) begin
        int dst = 3600 + k * 40;
        logic [7:0] c = 8'(8'hC0 + k);
        setColor(c);
        runCmd(dst, masks[k], 0, 33, 32, "R3 stipple cycles");
        for (int i = 0; i < 32; i++) if (masks[k][31 - i]) model[dst + i] = c;
        memCompare("R3 stipple mask order");
      end
    end

    // R7 stall: queued colour write must wait until the stipple ends
    setColor(8'h11);
    blitMode = 0;
    busWr({1'b0, 20'd3850, 3'b100}, 32'hFFFF0000, 4'hF);
    check(busy && !busReady, "R7 busy and not ready", {busy, busReady}, 2'b10);
    setColor(8'h22);               // stalls until stipple finishes
    check(!busy, "R7 stalled write accepted after idle", busy, 0);
    for (int i = 0; i < 16; i++) model[3850 + i] = 8'h11;
    runCmd(3900, {3'b000, 5'd3, 24'hFFFFFF}, 1, 5, 4, "R7 fill after stall");
    for (int i = 0; i < 4; i++) model[3900 + i] = 8'h22;
    memCompare("R7 stall ordering");

    // R8 reads return zero and start nothing
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = 24'h000104;
    @(negedge clk);
    check(busRdata == 32'h0, "R8 read data zero", busRdata, 0);
    @(negedge clk);
    check(!busy, "R8 read starts nothing", busy, 0);
    busValid = 0;
    // R8 partial writes ignored
    busWr(24'h000104, {8'h00, 24'hFFFFFF}, 4'h3);
    check(!busy, "R8 partial command ignored", busy, 0);
    busWr(24'h000010, 32'h000000EE, 4'h1);   // colour must stay 8'h22
    runCmd(3950, {3'b000, 5'd1, 24'hFFFFFF}, 1, 3, 2, "R8 fill cycles");
    for (int i = 0; i < 2; i++) model[3950 + i] = 8'h22;
    memCompare("R8 partial colour ignored");

    // R1 no strobes while idle over the whole run
    check(idleStrobes == 0, "R1 idle memory strobes", idleStrobes, 0);
    summary();
  end

endmodule